// File: doc/BRIEF.md
# Serial Flag Offset Shift Loader

This block takes the almost-empty and almost-full threshold offsets of a FIFO over a one-wire serial path. On each rising edge of the serial clock, while the active-low load select and the active-low shift enable are both low, one bit is taken from the serial data input. A complete programming set is 2N bits. It carries the empty offset first, least significant bit first, and then the full offset, ending with its most significant bit.

The bits collect in a working shift register. They reach the offset outputs, which feed the flag comparators, only when the 2N-th bit arrives. Raising either control line pauses the set. The bit counter keeps its place and continues with the next bit when both lines are low again. A set-complete indication lives in the serial clock domain. It is passed through a short synchronizer into the write clock domain, which gives a full-flag-valid output, and into the read clock domain, which gives an empty-flag-valid output. Both valid outputs drop as soon as a new set begins.

Top module: `serial_offset_loader`

## Requirements
- R1: A bit is taken from `sdi` on a rising `sclk` edge only when `load_n` and `sen_n` are both low at that edge.
- R2: In a complete set, the first bit taken lands in `offsets[0]` (empty offset LSB) and the 2N-th bit lands in `offsets[2N-1]` (full offset MSB). The empty offset occupies `offsets[N-1:0]` and the full offset occupies `offsets[2N-1:N]`.
- R3: A `sclk` edge with `load_n` low and `sen_n` high takes no bit and changes neither the outputs nor the bit position.
- R4: `offsets` holds its previous value until the edge that takes the 2N-th bit, and it changes at that edge.
- R5: `set_done` goes low at the edge that takes the first bit of a set and goes high at the edge that takes the 2N-th bit.
- R6: After a pause made by raising either control line, loading resumes with the next bit of the interrupted set.
- R7: After the edge that takes the 2N-th bit, `full_ofs_ok` goes high after three `wclk` edges and `empty_ofs_ok` goes high after three `rclk` edges.
- R8: `full_ofs_ok` and `empty_ofs_ok` are low whenever `set_done` is low.
- R9: After master reset (`rst_n` low), `offsets` holds the default empty and full offsets, `set_done` is high, both valid outputs are high, and the next bit taken is the first bit of a set.
- R10: A later complete set of 2N bits fully replaces the loaded offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial programming clock |
| wclk | input | 1 | Write-side clock for the full flag valid |
| rclk | input | 1 | Read-side clock for the empty flag valid |
| rst_n | input | 1 | Asynchronous master reset, active low |
| load_n | input | 1 | Offset load select, active low |
| sen_n | input | 1 | Serial shift enable, active low |
| sdi | input | 1 | Serial offset data |
| offsets | output | 2*OFS_W | Loaded offsets, {full, empty} |
| set_done | output | 1 | A complete set has been entered |
| full_ofs_ok | output | 1 | Full offset valid, write clock domain |
| empty_ofs_ok | output | 1 | Empty offset valid, read clock domain |

## Verification
`offsets` and `set_done` are due at the same `sclk` edge that takes the qualifying bit. The valid outputs drop combinationally with `set_done` and rise three edges of their own clock later. The bench drives all three clocks from one source. It sets inputs at the falling edge and samples one time unit after each rising edge. A reference model in the bench is updated at every edge. For the valid outputs, the model keeps a three-deep history of its expected `set_done`, so each result is compared in the cycle where it is due.

// File: rtl/sofl_pkg.sv
package sofl_pkg;
   function automatic int cnt_bits(input int total);
      return (total <= 2) ? 1 : $clog2(total);
   endfunction
endpackage

// File: rtl/sofl_bit_count.sv
module sofl_bit_count #(
   parameter int TOTAL = 32,
   localparam int CW = sofl_pkg::cnt_bits(TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [CW-1:0] cnt,
   output logic          last
);
   localparam logic [CW-1:0] LAST_IDX = CW'(TOTAL - 1);

   assign last = (cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (step)
         cnt <= last ? '0 : cnt + 1'b1;
   end

   AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt)); // R3
   AST_COUNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last) |=> (cnt == '0)); // R10
endmodule

// File: rtl/sofl_shift_reg.sv
module sofl_shift_reg #(
   parameter int                 TOTAL   = 32,
   parameter logic [TOTAL-1:0]   DEFAULT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             commit,
   input  logic             din,
   output logic [TOTAL-1:0] ofs
);
   logic [TOTAL-1:0] work;
   logic [TOTAL-1:0] next_work;

   generate
      if (TOTAL == 1) begin : g_single
         assign next_work = din;
      end else begin : g_multi
         assign next_work = {din, work[TOTAL-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         work <= '0;
      else if (step)
         work <= next_work;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ofs <= DEFAULT;
      else if (step && commit)
         ofs <= next_work;
   end

   AST_OFS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(step && commit) |=> $stable(ofs)); // R4
   AST_MSB_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && commit) |=> (ofs[TOTAL-1] == $past(din))); // R2
endmodule

// File: rtl/sofl_valid_sync.sv
module sofl_valid_sync #(
   parameter int STAGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   output logic ok
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= src;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign ok = chain[STAGES-1] & src;

   AST_OK_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok) |-> $past(src)); // R7
endmodule

// File: rtl/serial_offset_loader.sv
module serial_offset_loader #(
   parameter int                 OFS_W       = 16,
   parameter int                 SYNC_STAGES = 3,
   parameter logic [OFS_W-1:0]   DEF_EMPTY   = OFS_W'(16),
   parameter logic [OFS_W-1:0]   DEF_FULL    = OFS_W'(32),
   localparam int                TOTAL       = 2 * OFS_W,
   localparam int                CW          = sofl_pkg::cnt_bits(TOTAL)
) (
   input  logic             sclk,
   input  logic             wclk,
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic             sen_n,
   input  logic             sdi,
   output logic [TOTAL-1:0] offsets,
   output logic             set_done,
   output logic             full_ofs_ok,
   output logic             empty_ofs_ok
);
   generate
      if (OFS_W < 1) begin : g_bad_width
         $error("OFS_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          step;
   logic          last;
   logic [CW-1:0] cnt;

   assign step = !load_n && !sen_n;

   sofl_bit_count #(.TOTAL(TOTAL)) i_count (
      .clk(sclk), .rst_n(rst_n), .step(step), .cnt(cnt), .last(last)
   );

   sofl_shift_reg #(.TOTAL(TOTAL), .DEFAULT({DEF_FULL, DEF_EMPTY})) i_shift (
      .clk(sclk), .rst_n(rst_n), .step(step), .commit(last), .din(sdi),
      .ofs(offsets)
   );

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)
         set_done <= 1'b1;
      else if (step)
         set_done <= last;
   end

   sofl_valid_sync #(.STAGES(SYNC_STAGES)) i_wsync (
      .clk(wclk), .rst_n(rst_n), .src(set_done), .ok(full_ofs_ok)
   );

   sofl_valid_sync #(.STAGES(SYNC_STAGES)) i_rsync (
      .clk(rclk), .rst_n(rst_n), .src(set_done), .ok(empty_ofs_ok)
   );

   AST_DONE_CLEARS: assert property (@(posedge sclk) disable iff (!rst_n)
      (step && !last) |=> !set_done); // R5
   AST_DONE_SETS: assert property (@(posedge sclk) disable iff (!rst_n)
      (step && last) |=> set_done); // R5
   AST_IDLE_KEEPS_DONE: assert property (@(posedge sclk) disable iff (!rst_n)
      !step |=> $stable(set_done)); // R1
   AST_FLAGS_INVALID: assert property (@(posedge sclk) disable iff (!rst_n)
      !set_done |-> (!full_ofs_ok && !empty_ofs_ok)); // R8
endmodule

// File: tb/test_serial_offset_loader.sv
module test_serial_offset_loader;
   localparam int PERIOD = 10;
   localparam int N      = 16;
   localparam int TOT    = 2 * N;
   localparam logic [N-1:0] DE = 16'h0010;
   localparam logic [N-1:0] DF = 16'h0020;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load_n = 1'b1, sen_n = 1'b1, sdi = 1'b0;
   logic [TOT-1:0] offsets;
   logic set_done, full_ofs_ok, empty_ofs_ok;

   int checks = 0;
   int errors = 0;

   logic [TOT-1:0] m_work, m_ofs;
   int             m_pos;
   logic           m_done;
   logic [2:0]     m_hist;

   always #(PERIOD/2) clk = ~clk;

   serial_offset_loader #(.OFS_W(N), .SYNC_STAGES(3), .DEF_EMPTY(DE), .DEF_FULL(DF))
      i_serial_offset_loader (
         .sclk(clk), .wclk(clk), .rclk(clk), .rst_n(rst_n),
         .load_n(load_n), .sen_n(sen_n), .sdi(sdi),
         .offsets(offsets), .set_done(set_done),
         .full_ofs_ok(full_ofs_ok), .empty_ofs_ok(empty_ofs_ok));

   function automatic logic exp_ok(input logic done, input logic [2:0] h);
      return done & h[2];
   endfunction

   function automatic logic [TOT-1:0] pack_set(input logic [N-1:0] e, input logic [N-1:0] f);
      return {f, e};
   endfunction

   task automatic chk(input logic ok, input string req, input logic [TOT-1:0] act,
                      input logic [TOT-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all();
      chk(offsets == m_ofs, "R2 R4 offsets", offsets, m_ofs);
      chk(set_done == m_done, "R5 set_done", TOT'(set_done), TOT'(m_done));
      chk(full_ofs_ok == exp_ok(m_done, m_hist), "R7 R8 full_ofs_ok",
          TOT'(full_ofs_ok), TOT'(exp_ok(m_done, m_hist)));
      chk(empty_ofs_ok == exp_ok(m_done, m_hist), "R7 R8 empty_ofs_ok",
          TOT'(empty_ofs_ok), TOT'(exp_ok(m_done, m_hist)));
   endtask

   task automatic step(input logic l, input logic s, input logic d);
      @(negedge clk);
      load_n = l; sen_n = s; sdi = d;
      @(posedge clk);
      #1;
      m_hist = {m_hist[1:0], m_done};
      if (!l && !s) begin   // R1: only both-low edges take a bit
         m_work = {d, m_work[TOT-1:1]};
         if (m_pos == TOT - 1) begin
            m_ofs  = m_work;
            m_done = 1'b1;
            m_pos  = 0;
         end else begin
            m_done = 1'b0;
            m_pos++;
         end
      end
      check_all();
   endtask

   task automatic load_set(input logic [TOT-1:0] v);
      for (int i = 0; i < TOT; i++) step(1'b0, 1'b0, v[i]);
   endtask

   initial begin
      #(PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      m_work = '0; m_ofs = pack_set(DE, DF); m_pos = 0; m_done = 1'b1; m_hist = 3'b111;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9: reset state
      chk(offsets == pack_set(DE, DF), "R9 reset offsets", offsets, pack_set(DE, DF));
      chk(set_done && full_ofs_ok && empty_ofs_ok, "R9 reset flags",
          TOT'({set_done, full_ofs_ok, empty_ofs_ok}), TOT'(3'b111));

      // R3: load low, enable high takes nothing
      repeat (5) step(1'b0, 1'b1, 1'b1);
      // R2 R7: a full set, then idle while flags become valid
      load_set(pack_set(16'hA5C3, 16'h1F0E));
      repeat (4) step(1'b1, 1'b1, 1'b0);
      chk(offsets == pack_set(16'hA5C3, 16'h1F0E), "R2 field placement",
          offsets, pack_set(16'hA5C3, 16'h1F0E));
      chk(full_ofs_ok && empty_ofs_ok, "R7 valid after three edges",
          TOT'({full_ofs_ok, empty_ofs_ok}), TOT'(2'b11));

      // R6: interrupted set resumes at next bit
      begin
         logic [TOT-1:0] v;
         v = pack_set(16'h0003, 16'hFFFC);
         for (int i = 0; i < TOT; i++) begin
            if (i == 7)  repeat (3) step(1'b1, 1'b0, 1'b1);
            if (i == 20) repeat (3) step(1'b0, 1'b1, 1'b0);
            step(1'b0, 1'b0, v[i]);
         end
         chk(offsets == v, "R6 resumed set", offsets, v);
      end

      // R10: reprogram replaces
      load_set(pack_set(16'h8001, 16'h7FFE));
      chk(offsets == pack_set(16'h8001, 16'h7FFE), "R10 reprogram",
          offsets, pack_set(16'h8001, 16'h7FFE));

      // R1: random control and data
      for (int i = 0; i < 2000; i++)
         step(($urandom % 5) == 0, ($urandom % 5) == 0, $urandom % 2);
      repeat (4) step(1'b1, 1'b1, 1'b0);

      // R9: reset mid-set returns to first bit
      for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      load_n = 1'b1; sen_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      m_work = '0; m_ofs = pack_set(DE, DF); m_pos = 0; m_done = 1'b1; m_hist = 3'b111;
      #1;
      check_all();
      load_set(pack_set(16'h1234, 16'h5678));
      chk(offsets == pack_set(16'h1234, 16'h5678), "R9 counter restarted",
          offsets, pack_set(16'h1234, 16'h5678));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule